// File: doc/BRIEF.md
# DRAM Bank Queue Command Scheduler

This block sits between a requester and a DRAM channel. Each incoming read or write request is sorted by its physical address into a queue for its bank. Every cycle the scheduler looks at the head request of each bank queue. It decides which banks may legally receive a command now, and grants the shared command bus to one of them in rotating order. A granted request leaves its queue and appears on the command issue port for that single cycle.

A legal issue depends on four timing rules. The first is the row cycle time of the target bank. The second is how long the bus is occupied by the previous command. The third is an extra gap when consecutive reads change rank. The fourth is an extra gap when a write follows a read. A completion returns a fixed number of cycles after each issue, whatever the low address bits are. The completion is either read data valid or a write acknowledge, and it carries the original tag. The requester uses the tag to match completions to its requests.

Top module: `dbq_scheduler`

## Requirements
- R1: The bank index is address bits [10:8] and the rank is address bit 11; the issued command reports both on `cmd_bank` and `cmd_rank`, and address bits [5:0], [7:6], 12 and 13 upward do not affect queue selection.
- R2: Each bank queue holds at most 12 requests; `req_ready` is low exactly when the queue addressed by `req_addr[10:8]` holds 12 entries, and a request is taken only when `req_valid` and `req_ready` are both high.
- R3: After a command issues to a bank in cycle t, that bank issues nothing before cycle t+11.
- R4: Each cycle, if any bank has a queued head request that meets R3, R5, R6 and R7, exactly one such bank is granted. Banks are searched in rotating order from a pointer that starts at bank 0 after reset and moves to the bank after the one just granted.
- R5: A read following a read to the other rank issues no earlier than 3 cycles after it (bus time plus one).
- R6: A write following a read issues no earlier than 4 cycles after it (bus time plus two).
- R7: Any two commands are at least 2 cycles apart; all other pairs (write then read, write then write, read then read to the same rank) need only this gap.
- R8: A command issued in cycle t produces `rsp_valid` in cycle t+12, with `rsp_tag` equal to the request tag and `rsp_write` equal to its write flag (1 = write acknowledge, 0 = read data).
- R9: Requests to one bank are issued in the order they were accepted.
- R10: After reset no command or response is driven and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Target bank queue can take the request |
| req_addr | input | 32 | Physical byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tag | input | 4 | Requester tag, returned with the completion |
| cmd_valid | output | 1 | A command issues this cycle |
| cmd_bank | output | 3 | Bank of the issued command |
| cmd_rank | output | 1 | Rank of the issued command |
| cmd_write | output | 1 | Issued command is a write |
| cmd_addr | output | 32 | Full address of the issued command |
| cmd_tag | output | 4 | Tag of the issued command |
| rsp_valid | output | 1 | Completion present |
| rsp_write | output | 1 | 1 = write acknowledge, 0 = read data |
| rsp_tag | output | 4 | Tag of the completed request |

## Verification
In one cycle, a request can be pushed into a bank queue while the arbiter pops the head of that same queue. A response can also leave the latency pipeline in the same cycle that a fresh command enters it. The bench provokes the first case by streaming writes into one bank until its queue fills and the input stalls, so pushes and grants to that bank coincide. It provokes the second with dense mixed traffic whose issues fall 12 cycles apart. A behavioural model with its own queues and timestamps predicts `req_ready`, the granted bank and tag, and every completion on every clock. Separate history checks measure the spacing between observed commands against each timing rule.

// File: rtl/dbq_pkg.sv
package dbq_pkg;

  // Minimum distance, in cycles, between the previous command and the next one.
  function automatic int unsigned cmd_spacing(
    input logic        prev_wr,
    input logic        prev_rank,
    input logic        nxt_wr,
    input logic        nxt_rank,
    input int unsigned t_bus,
    input int unsigned t_rank,
    input int unsigned t_rw
  );
    int unsigned g;
    g = t_bus;
    if (!prev_wr && !nxt_wr && (prev_rank != nxt_rank)) g = g + t_rank;
    if (!prev_wr && nxt_wr) g = g + t_rw;
    return g;
  endfunction

  // Rotating pointer step: the bank after the granted one.
  function automatic int unsigned rr_next(input int unsigned idx, input int unsigned n);
    return (idx + 1) % n;
  endfunction

endpackage

// File: rtl/dbq_fifo.sv
module dbq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

endmodule

// File: rtl/dbq_rr_arb.sv
module dbq_rr_arb #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);
  always_comb begin
    int k;
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int i = 0; i < N; i++) begin
      k = (int'(ptr) + i) % N;
      if (!any && req[k]) begin
        any     = 1'b1;
        gnt[k]  = 1'b1;
        gnt_idx = IW'(k);
      end
    end
  end
endmodule

// File: rtl/dbq_resp_pipe.sv
module dbq_resp_pipe #(
  parameter int LAT   = 12,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_write,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  output logic             out_write,
  output logic [TAG_W-1:0] out_tag
);
  logic             st_v [LAT];
  logic             st_w [LAT];
  logic [TAG_W-1:0] st_t [LAT];

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    logic             src_v, src_w;
    logic [TAG_W-1:0] src_t;
    if (s == 0) begin : g_first
      assign src_v = in_valid;
      assign src_w = in_write;
      assign src_t = in_tag;
    end else begin : g_next
      assign src_v = st_v[s-1];
      assign src_w = st_w[s-1];
      assign src_t = st_t[s-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) st_v[s] <= 1'b0;
      else        st_v[s] <= src_v;
      st_w[s] <= src_w;
      st_t[s] <= src_t;
    end
  end

  assign out_valid = st_v[LAT-1];
  assign out_write = st_w[LAT-1];
  assign out_tag   = st_t[LAT-1];
endmodule

// File: rtl/dbq_scheduler.sv
module dbq_scheduler
  import dbq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int TAG_W     = 4,
  parameter int NUM_BANKS = 8,
  parameter int BANK_LSB  = 8,
  parameter int RANK_BIT  = 11,
  parameter int Q_DEPTH   = 12,
  parameter int T_BANK    = 11,
  parameter int T_BUS     = 2,
  parameter int T_RANK    = 1,
  parameter int T_RW      = 2,
  parameter int T_LAT     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              cmd_valid,
  output logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
  output logic              cmd_rank,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [TAG_W-1:0]  cmd_tag,
  output logic              rsp_valid,
  output logic              rsp_write,
  output logic [TAG_W-1:0]  rsp_tag
);
  localparam int BW      = $clog2(NUM_BANKS);
  localparam int EW      = ADDR_W + 1 + TAG_W;    // {addr, write, tag}
  localparam int WR_POS  = TAG_W;
  localparam int RK_POS  = TAG_W + 1 + RANK_BIT;
  localparam int MAXGAP  = T_BUS + T_RANK + T_RW;
  localparam int SW      = $clog2(MAXGAP + 1);
  localparam int TW      = $clog2(T_BANK + 1);

  // Named internal events, observed by the bound checker.
  logic [NUM_BANKS-1:0] q_empty, bank_full, push_vec, elig_vec, grant_vec;
  logic                 target_full, accept, issue;
  logic [BW-1:0]        req_bank, gnt_idx, rr_ptr;
  logic [EW-1:0]        head [NUM_BANKS];
  logic [EW-1:0]        sel;

  // Bus history shared by all banks.
  logic [SW-1:0] since;
  logic          last_wr, last_rank;

  assign req_bank    = req_addr[BANK_LSB +: BW];
  assign target_full = bank_full[req_bank];
  assign req_ready   = !target_full;
  assign accept      = req_valid && req_ready;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [TW-1:0] btimer;
    logic          h_wr, h_rank;

    assign push_vec[b] = accept && (req_bank == BW'(b));

    dbq_fifo #(.W(EW), .DEPTH(Q_DEPTH)) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_vec[b]),
      .din   ({req_addr, req_write, req_tag}),
      .pop   (grant_vec[b]),
      .dout  (head[b]),
      .empty (q_empty[b]),
      .full  (bank_full[b])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)              btimer <= '0;
      else if (grant_vec[b])   btimer <= TW'(T_BANK - 1);
      else if (btimer != '0)   btimer <= btimer - 1'b1;
    end

    assign h_wr   = head[b][WR_POS];
    assign h_rank = head[b][RK_POS];
    assign elig_vec[b] = !q_empty[b] && (btimer == '0) &&
                         (32'(since) >= cmd_spacing(last_wr, last_rank, h_wr, h_rank,
                                                    T_BUS, T_RANK, T_RW));
  end

  dbq_rr_arb #(.N(NUM_BANKS), .IW(BW)) u_arb (
    .req     (elig_vec),
    .ptr     (rr_ptr),
    .gnt     (grant_vec),
    .gnt_idx (gnt_idx),
    .any     (issue)
  );

  assign sel       = head[gnt_idx];
  assign cmd_valid = issue;
  assign cmd_bank  = gnt_idx;
  assign cmd_addr  = sel[EW-1 -: ADDR_W];
  assign cmd_write = sel[WR_POS];
  assign cmd_tag   = sel[TAG_W-1:0];
  assign cmd_rank  = sel[RK_POS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since     <= SW'(MAXGAP);
      last_wr   <= 1'b1;
      last_rank <= 1'b0;
      rr_ptr    <= '0;
    end else if (issue) begin
      since     <= SW'(1);
      last_wr   <= cmd_write;
      last_rank <= cmd_rank;
      rr_ptr    <= BW'(rr_next(int'(gnt_idx), NUM_BANKS));
    end else if (since != SW'(MAXGAP)) begin
      since <= since + 1'b1;
    end
  end

  dbq_resp_pipe #(.LAT(T_LAT), .TAG_W(TAG_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (issue),
    .in_write  (cmd_write),
    .in_tag    (cmd_tag),
    .out_valid (rsp_valid),
    .out_write (rsp_write),
    .out_tag   (rsp_tag)
  );

endmodule

// File: rtl/dbq_scheduler_chk.sv
module dbq_scheduler_chk #(
  parameter int NUM_BANKS = 8,
  parameter int BW        = 3,
  parameter int T_BANK    = 11,
  parameter int T_BUS     = 2,
  parameter int T_RANK    = 1,
  parameter int T_RW      = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 target_full,
  input logic                 cmd_valid,
  input logic [BW-1:0]        cmd_bank,
  input logic                 cmd_rank,
  input logic                 cmd_write,
  input logic [NUM_BANKS-1:0] elig_vec,
  input logic [NUM_BANKS-1:0] grant_vec
);
  logic [15:0] gap_cnt;
  logic        seen, pw, pr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      seen    <= 1'b0;
      pw      <= 1'b0;
      pr      <= 1'b0;
    end else if (cmd_valid) begin
      gap_cnt <= 16'd1;
      seen    <= 1'b1;
      pw      <= cmd_write;
      pr      <= cmd_rank;
    end else if (gap_cnt != 16'hFFFF) begin
      gap_cnt <= gap_cnt + 16'd1;
    end
  end

  assert_bus_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && seen |-> gap_cnt >= 16'(T_BUS));

  assert_rank_switch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && seen && !pw && !cmd_write && (pr != cmd_rank) |-> gap_cnt >= 16'(T_BUS + T_RANK));

  assert_read_to_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && seen && !pw && cmd_write |-> gap_cnt >= 16'(T_BUS + T_RW));

  assert_full_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && target_full |-> !req_ready);

  assert_single_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  assert_grant_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec & ~elig_vec) == '0);

  assert_work_conserving_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|elig_vec) |-> cmd_valid);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    logic [15:0] bcnt;
    logic        bseen;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bcnt  <= '0;
        bseen <= 1'b0;
      end else if (cmd_valid && (cmd_bank == BW'(b))) begin
        bcnt  <= 16'd1;
        bseen <= 1'b1;
      end else if (bcnt != 16'hFFFF) begin
        bcnt <= bcnt + 16'd1;
      end
    end
    assert_bank_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && (cmd_bank == BW'(b)) && bseen |-> bcnt >= 16'(T_BANK));
  end
endmodule

bind dbq_scheduler dbq_scheduler_chk #(
  .NUM_BANKS (NUM_BANKS),
  .BW        (BW),
  .T_BANK    (T_BANK),
  .T_BUS     (T_BUS),
  .T_RANK    (T_RANK),
  .T_RW      (T_RW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .target_full (target_full),
  .cmd_valid   (cmd_valid),
  .cmd_bank    (cmd_bank),
  .cmd_rank    (cmd_rank),
  .cmd_write   (cmd_write),
  .elig_vec    (elig_vec),
  .grant_vec   (grant_vec)
);

// File: tb/dbq_scheduler_test.sv
module dbq_scheduler_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_addr;
  logic [3:0]  req_tag;
  logic        cmd_valid, cmd_rank, cmd_write;
  logic [2:0]  cmd_bank;
  logic [31:0] cmd_addr;
  logic [3:0]  cmd_tag;
  logic        rsp_valid, rsp_write;
  logic [3:0]  rsp_tag;

  dbq_scheduler uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_tag(req_tag),
    .cmd_valid(cmd_valid), .cmd_bank(cmd_bank), .cmd_rank(cmd_rank),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_tag(cmd_tag),
    .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_tag(rsp_tag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // Reference model state: entry = {addr[31:0], write, tag[3:0]}
  logic [36:0] mq [NB][$];
  int bank_ready [NB];
  int last_cyc = -1000;
  bit last_wr = 1, last_rank = 0;
  int rr = 0;
  bit ev [64];
  bit ew [64];
  logic [3:0] et [64];

  // Observed history of the design's commands
  int dut_bank_last [NB];
  int dut_last = -1000;
  bit dut_last_wr = 1, dut_last_rank = 0;

  logic [3:0] tag_ctr = 0;
  bit saw_stall = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s cycle=%0d actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  function automatic int spacing(input bit pw, input bit pr, input bit w, input bit r);
    int g = 2;
    if (!pw && !w && pr != r) g += 1;
    if (!pw && w) g += 2;
    return g;
  endfunction

  function automatic logic [31:0] mk(input int bank, input bit rank, input int row);
    return (32'(row) << 13) | (32'(rank) << 11) | (32'(bank) << 8) | 32'h0000_00C5;
  endfunction

  // One cycle: called right after a falling edge.
  task automatic step(input bit v, input logic [31:0] a, input bit w, output bit took);
    int g, b;
    bit exp_ready;
    req_valid = v; req_addr = a; req_write = w; req_tag = tag_ctr;
    #1;
    b = int'(a[10:8]);
    exp_ready = mq[b].size() < 12;
    g = -1;
    for (int i = 0; i < NB; i++) begin
      int k = (rr + i) % NB;
      if (g < 0 && mq[k].size() > 0 && cyc >= bank_ready[k] &&
          (cyc - last_cyc) >= spacing(last_wr, last_rank, mq[k][0][4], mq[k][0][16]))
        g = k;
    end
    // R2: queue full stall
    check(req_ready == exp_ready, "R2", "req_ready", 64'(req_ready), 64'(exp_ready));
    // R4: a command issues exactly when some bank is eligible
    check(cmd_valid == (g >= 0), "R4", "cmd_valid", 64'(cmd_valid), 64'(g >= 0));
    if (cmd_valid && g >= 0) begin
      check(int'(cmd_bank) == g, "R4", "cmd_bank rotation", 64'(cmd_bank), 64'(g));
      check(cmd_tag == mq[g][0][3:0], "R9", "cmd_tag order", 64'(cmd_tag), 64'(mq[g][0][3:0]));
      check(cmd_write == mq[g][0][4], "R9", "cmd_write", 64'(cmd_write), 64'(mq[g][0][4]));
      check(cmd_addr == mq[g][0][36:5], "R9", "cmd_addr", 64'(cmd_addr), 64'(mq[g][0][36:5]));
    end
    // R8: fixed-latency completion
    check(rsp_valid == ev[cyc % 64], "R8", "rsp_valid", 64'(rsp_valid), 64'(ev[cyc % 64]));
    if (rsp_valid && ev[cyc % 64]) begin
      check(rsp_tag == et[cyc % 64], "R8", "rsp_tag", 64'(rsp_tag), 64'(et[cyc % 64]));
      check(rsp_write == ew[cyc % 64], "R8", "rsp_write", 64'(rsp_write), 64'(ew[cyc % 64]));
    end
    // Rule checks on the observed command stream
    if (cmd_valid) begin
      int ob = int'(cmd_bank);
      check(cmd_bank == cmd_addr[10:8], "R1", "bank decode", 64'(cmd_bank), 64'(cmd_addr[10:8]));
      check(cmd_rank == cmd_addr[11], "R1", "rank decode", 64'(cmd_rank), 64'(cmd_addr[11]));
      check(cyc - dut_bank_last[ob] >= 11, "R3", "bank cycle gap",
            64'(cyc - dut_bank_last[ob]), 64'd11);
      check(cyc - dut_last >= 2, "R7", "bus gap", 64'(cyc - dut_last), 64'd2);
      if (!dut_last_wr && !cmd_write && dut_last_rank != cmd_rank)
        check(cyc - dut_last >= 3, "R5", "rank switch gap", 64'(cyc - dut_last), 64'd3);
      if (!dut_last_wr && cmd_write)
        check(cyc - dut_last >= 4, "R6", "read to write gap", 64'(cyc - dut_last), 64'd4);
      dut_bank_last[ob] = cyc;
      dut_last = cyc;
      dut_last_wr = cmd_write;
      dut_last_rank = cmd_rank;
    end
    if (v && !req_ready) saw_stall = 1;
    // Model update
    ev[cyc % 64] = 0;
    if (g >= 0) begin
      logic [36:0] e = mq[g].pop_front();
      bank_ready[g] = cyc + 11;
      last_cyc = cyc;
      last_wr = e[4];
      last_rank = e[16];
      rr = (g + 1) % NB;
      ev[(cyc + 12) % 64] = 1;
      ew[(cyc + 12) % 64] = e[4];
      et[(cyc + 12) % 64] = e[3:0];
    end
    took = v && exp_ready;
    if (took) begin
      mq[b].push_back({a, w, tag_ctr});
      tag_ctr++;
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(input int n);
    bit t;
    for (int i = 0; i < n; i++) step(0, 32'h0, 0, t);
  endtask

  task automatic send(input logic [31:0] a, input bit w);
    bit t = 0;
    while (!t) step(1, a, w, t);
  endtask

  function automatic bit model_empty();
    for (int i = 0; i < NB; i++) if (mq[i].size() != 0) return 0;
    return 1;
  endfunction

  initial begin
    bit t;
    for (int i = 0; i < NB; i++) begin bank_ready[i] = 0; dut_bank_last[i] = -1000; end
    for (int i = 0; i < 64; i++) begin ev[i] = 0; ew[i] = 0; et[i] = 0; end
    rst_n = 0; req_valid = 0; req_addr = 0; req_write = 0; req_tag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R10: reset state
    check(req_ready == 1'b1, "R10", "req_ready after reset", 64'(req_ready), 64'd1);
    check(cmd_valid == 1'b0, "R10", "cmd_valid after reset", 64'(cmd_valid), 64'd0);
    check(rsp_valid == 1'b0, "R10", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    @(negedge clk);

    // Single read, latency (R8)
    send(mk(0, 0, 5), 0);
    idle(16);
    // One read per bank, rotation and bus spacing (R4, R7)
    for (int b = 0; b < NB; b++) send(mk(b, 0, b + 1), 0);
    idle(30);
    // Same bank back to back (R3, R9)
    for (int i = 0; i < 4; i++) send(mk(2, i[0], 40 + i), i[0]);
    idle(50);
    // Rank switch between reads (R5), low/upper bits vary (R1)
    send(mk(1, 0, 7) | 32'h0000_1000, 0);
    send(mk(4, 1, 9), 0);
    send(mk(5, 1, 3), 0);
    idle(20);
    // Read followed by writes (R6)
    send(mk(3, 0, 2), 0);
    send(mk(6, 0, 2), 1);
    send(mk(0, 1, 2), 1);
    idle(20);
    // Fill one bank until the input stalls (R2)
    for (int i = 0; i < 16; i++) send(mk(7, i[1], 100 + i), 1);
    check(saw_stall, "R2", "full queue stalled input", 64'(saw_stall), 64'd1);
    idle(10);
    // Mixed traffic
    for (int i = 0; i < 600; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      step(lfsr[3:0] < 4'd11, {lfsr[31:13], lfsr[9], lfsr[12:11], lfsr[7:5], lfsr[17:10]},
           lfsr[20], t);
    end
    // Drain
    while (!model_empty()) idle(1);
    idle(20);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule